// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This unit sits between a core's load/store pipe and the address translation stage. Each request carries a virtual address, a size code, a load/store flag, a signedness flag and store data. The unit checks the address against the access size. An aligned request goes downstream with its byte lanes and write strobes placed from the low address bits. A misaligned request is consumed locally. It raises a trap whose code tells loads from stores, and the offending address is captured in a register the core can read.

Load data returned by memory arrives as a raw 64-bit word. The unit picks the addressed bytes out of that word and widens them to register width, with zero fill or sign fill as the request asked. Only one load may be outstanding at a time. Request, downstream, response and result channels all use valid/ready. A transfer happens on a clock edge where both valid and ready are high. A source keeps its valid and payload stable until that transfer. No ready depends on the same channel's valid.

Top module: `lsu_align_unit`

## Requirements
- R1: The size code s (0, 1, 2, 3 for 1, 2, 4, 8 bytes) marks a request misaligned when the address modulo 2^s is nonzero. Byte accesses are never misaligned.
- R2: One cycle after a misaligned load is accepted, trap_valid is 1 for exactly one cycle and trap_cause is 2'b01. trap_valid is 0 in every other cycle, and trap_cause is 2'b00 whenever no trap is signalled.
- R3: One cycle after a misaligned store is accepted, trap_valid is 1 and trap_cause is 2'b10.
- R4: fault_addr takes the faulting address one cycle after a misaligned request is accepted. It keeps that value through aligned traffic until the next fault.
- R5: A misaligned request is accepted (req_ready = 1) when no load is pending. It never raises mem_valid, so nothing is issued downstream and memory is not written.
- R6: An aligned request with no load pending drives mem_valid with mem_addr = req_addr, mem_store = req_store and mem_fetch = 0 in the same cycle. req_ready follows mem_ready, so downstream back-pressure stalls the request.
- R7: For an aligned store, mem_wdata is req_wdata shifted left by 8 times addr[2:0]. mem_wstrb has 2^s ones starting at bit addr[2:0], with bit i enabling byte lane i (bits 8i+7..8i).
- R8: For a load, mem_wstrb is all zero.
- R9: An unsigned load returns 2^s bytes taken from the response word starting at byte lane addr[2:0], zero-extended to 64 bits.
- R10: A signed load returns the same bytes sign-extended from the top bit of the selected field.
- R11: While a load is pending, req_ready and mem_valid are 0. out_valid equals rsp_valid and rsp_ready equals out_ready, and the pending state clears on the result transfer.
- R12: After reset, trap_valid is 0, trap_cause is 0, fault_addr is 0, no load is pending and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Unit accepts the request |
| req_addr | input | ADDR_W | Virtual address |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_store | input | 1 | 1 for store, 0 for load |
| req_signed | input | 1 | 1 for sign extension of load data |
| req_wdata | input | DATA_W | Store data, right-aligned |
| mem_valid | output | 1 | Downstream request valid |
| mem_ready | input | 1 | Downstream accepts |
| mem_addr | output | ADDR_W | Address to translation |
| mem_store | output | 1 | Write flag to translation |
| mem_fetch | output | 1 | Instruction-fetch flag, always 0 |
| mem_wdata | output | DATA_W | Lane-placed store data |
| mem_wstrb | output | DATA_W/8 | Byte write enables |
| rsp_valid | input | 1 | Load response word valid |
| rsp_ready | output | 1 | Unit takes the response |
| rsp_data | input | DATA_W | Raw load response word |
| out_valid | output | 1 | Extended load result valid |
| out_ready | input | 1 | Core takes the result |
| out_data | output | DATA_W | Extended load result |
| trap_valid | output | 1 | Misalignment trap pulse |
| trap_cause | output | 2 | 01 load misaligned, 10 store misaligned |
| fault_addr | output | ADDR_W | Last faulting virtual address |

## Verification
Loads are tried at every size with byte lanes away from zero and with data whose selected top bit is set, both signed and unsigned. These cases separate a correct lane shift from an unshifted read and sign fill from zero fill. Misaligned cases include an 8-byte access at a 4-byte boundary and odd-address bytes, which tell a true modulo test from a fixed low-bit check. Stores at several offsets expose strobe and lane errors. Stalled downstream, a pending load and a held-off result check that back-pressure blocks new traffic, and faults followed by aligned traffic show whether the fault address holds.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam int unsigned SIZE_W = 2;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TRAP_NONE     = 2'b00,
    TRAP_LD_MISAL = 2'b01,
    TRAP_ST_MISAL = 2'b10
  } trap_code_e;

  typedef struct packed {
    logic [SIZE_W-1:0] size;
    logic              sgn;
  } ld_ctl_t;
endpackage

// File: rtl/lsu_misalign_chk.sv
module lsu_misalign_chk #(
  parameter int unsigned OFF_W = 3
) (
  input  logic [OFF_W-1:0]                      lane_off,
  input  logic [lsu_align_pkg::SIZE_W-1:0]      size,
  output logic                                  misal
);
  // an address bit below the size's power of two being set breaks alignment
  always_comb begin
    misal = 1'b0;
    for (int i = 0; i < OFF_W; i++) begin
      if (lane_off[i] && (int'(size) > i)) misal = 1'b1;
    end
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [$clog2(DATA_W/8)-1:0]      lane_off,
  input  logic [lsu_align_pkg::SIZE_W-1:0] size,
  input  logic                             is_store,
  input  logic [DATA_W-1:0]                wdata,
  output logic [DATA_W-1:0]                lane_data,
  output logic [DATA_W/8-1:0]              strb
);
  localparam int unsigned LANES = DATA_W / 8;

  logic [LANES-1:0] strb_base;

  for (genvar g = 0; g < LANES; g++) begin : g_base
    assign strb_base[g] = (g < (1 << size));
  end

  assign strb      = is_store ? (strb_base << lane_off) : '0;
  assign lane_data = wdata << {lane_off, 3'b000};
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [$clog2(DATA_W/8)-1:0]      lane_off,
  input  logic [lsu_align_pkg::SIZE_W-1:0] size,
  input  logic                             sgn,
  input  logic [DATA_W-1:0]                raw_data,
  output logic [DATA_W-1:0]                ext_data
);
  localparam int unsigned LANES = DATA_W / 8;

  logic [DATA_W-1:0] shifted;
  logic              top_bit;
  logic [7:0]        fill;

  assign shifted = raw_data >> {lane_off, 3'b000};
  assign top_bit = shifted[(8 << size) - 1];
  assign fill    = {8{sgn & top_bit}};

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      ext_data[8*i +: 8] = (i < (1 << size)) ? shifted[8*i +: 8] : fill;
    end
  end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_align_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [SIZE_W-1:0]    req_size,
  input  logic                 req_store,
  input  logic                 req_signed,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_store,
  output logic                 mem_fetch,
  output logic [DATA_W-1:0]    mem_wdata,
  output logic [DATA_W/8-1:0]  mem_wstrb,
  input  logic                 rsp_valid,
  output logic                 rsp_ready,
  input  logic [DATA_W-1:0]    rsp_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DATA_W-1:0]    out_data,
  output logic                 trap_valid,
  output logic [1:0]           trap_cause,
  output logic [ADDR_W-1:0]    fault_addr
);
  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned OFF_W = $clog2(LANES);

  logic [OFF_W-1:0] req_off;
  logic             misal;
  logic             accept;
  logic             pend_q;
  logic [OFF_W-1:0] pend_off_q;
  ld_ctl_t          pend_ctl_q;
  trap_code_e       trap_q;
  logic             trap_vld_q;
  logic [ADDR_W-1:0] fault_q;

  assign req_off = req_addr[OFF_W-1:0];

  lsu_misalign_chk #(.OFF_W(OFF_W)) u_mis (
    .lane_off (req_off),
    .size     (req_size),
    .misal    (misal)
  );

  lsu_store_lane #(.DATA_W(DATA_W)) u_st (
    .lane_off  (req_off),
    .size      (req_size),
    .is_store  (req_store),
    .wdata     (req_wdata),
    .lane_data (mem_wdata),
    .strb      (mem_wstrb)
  );

  lsu_load_extend #(.DATA_W(DATA_W)) u_ld (
    .lane_off (pend_off_q),
    .size     (pend_ctl_q.size),
    .sgn      (pend_ctl_q.sgn),
    .raw_data (rsp_data),
    .ext_data (out_data)
  );

  // request side: faults are swallowed here, aligned traffic passes through
  assign req_ready = !pend_q && (misal || mem_ready);
  assign mem_valid = req_valid && !misal && !pend_q;
  assign mem_addr  = req_addr;
  assign mem_store = req_store;
  assign mem_fetch = 1'b0;
  assign accept    = req_valid && req_ready;

  // response side: only live while a load waits
  assign out_valid = pend_q && rsp_valid;
  assign rsp_ready = pend_q && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_vld_q <= 1'b0;
      trap_q     <= TRAP_NONE;
      fault_q    <= '0;
    end else begin
      trap_vld_q <= accept && misal;
      if (accept && misal) begin
        trap_q  <= req_store ? TRAP_ST_MISAL : TRAP_LD_MISAL;
        fault_q <= req_addr;
      end else begin
        trap_q  <= TRAP_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      pend_off_q <= '0;
      pend_ctl_q <= '0;
    end else if (accept && !misal && !req_store) begin
      pend_q          <= 1'b1;
      pend_off_q      <= req_off;
      pend_ctl_q.size <= req_size;
      pend_ctl_q.sgn  <= req_signed;
    end else if (out_valid && out_ready) begin
      pend_q <= 1'b0;
    end
  end

  assign trap_valid = trap_vld_q;
  assign trap_cause = trap_q;
  assign fault_addr = fault_q;
endmodule

// File: rtl/lsu_align_unit_chk.sv
module lsu_align_unit_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_ready,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [1:0]          req_size,
  input logic                req_store,
  input logic                mem_valid,
  input logic                mem_ready,
  input logic                mem_store,
  input logic [DATA_W/8-1:0] mem_wstrb,
  input logic                trap_valid,
  input logic [1:0]          trap_cause,
  input logic [ADDR_W-1:0]   fault_addr,
  input logic                out_valid,
  input logic                pend
);
  logic [ADDR_W-1:0] size_mask;
  logic              bad_align;
  logic              fault_take;

  assign size_mask  = ({{(ADDR_W-1){1'b0}}, 1'b1} << req_size) - 1'b1;
  assign bad_align  = (req_addr & size_mask) != '0;
  assign fault_take = req_valid && req_ready && bad_align;

  p_fault_no_issue_r5: assert property (@(posedge clk) disable iff (rst)
    req_valid && bad_align |-> !mem_valid);

  p_fault_consumed_r5: assert property (@(posedge clk) disable iff (rst)
    req_valid && bad_align && !pend |-> req_ready);

  p_aligned_pass_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid && !bad_align && !pend |-> mem_valid && (req_ready == mem_ready));

  p_ld_trap_r2: assert property (@(posedge clk) disable iff (rst)
    fault_take && !req_store |=> trap_valid && trap_cause == 2'b01);

  p_st_trap_r3: assert property (@(posedge clk) disable iff (rst)
    fault_take && req_store |=> trap_valid && trap_cause == 2'b10);

  p_no_stray_trap_r2: assert property (@(posedge clk) disable iff (rst)
    !fault_take |=> !trap_valid && trap_cause == 2'b00);

  p_fault_capture_r4: assert property (@(posedge clk) disable iff (rst)
    fault_take |=> fault_addr == $past(req_addr));

  p_fault_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !fault_take |=> $stable(fault_addr));

  p_load_no_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_store |-> mem_wstrb == '0);

  p_pending_blocks_r11: assert property (@(posedge clk) disable iff (rst)
    pend |-> !mem_valid && !req_ready);

  p_result_needs_pend_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> pend);
endmodule

bind lsu_align_unit lsu_align_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_size   (req_size),
  .req_store  (req_store),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_store  (mem_store),
  .mem_wstrb  (mem_wstrb),
  .trap_valid (trap_valid),
  .trap_cause (trap_cause),
  .fault_addr (fault_addr),
  .out_valid  (out_valid),
  .pend       (pend_q)
);

// File: tb/lsu_align_unit_test.sv
`timescale 1ns/1ps
module lsu_align_unit_test;
  localparam int AW = 64;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [DW-1:0] req_wdata = '0;
  logic mem_ready = 1'b0, rsp_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic req_ready, mem_valid, mem_store, mem_fetch, rsp_ready, out_valid, trap_valid;
  logic [AW-1:0] mem_addr, fault_addr;
  logic [DW-1:0] mem_wdata, out_data;
  logic [7:0] mem_wstrb;
  logic [1:0] trap_cause;

  int n_tests = 0;
  int n_fail = 0;
  logic [63:0] sb_q[$];
  logic [AW-1:0] exp_fault = '0;

  always #5 clk = ~clk;

  lsu_align_unit uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_store(req_store), .req_signed(req_signed),
    .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_store(mem_store), .mem_fetch(mem_fetch), .mem_wdata(mem_wdata),
    .mem_wstrb(mem_wstrb),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .trap_valid(trap_valid), .trap_cause(trap_cause), .fault_addr(fault_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_load(input logic [63:0] d, input int off, input int sz, input bit sg);
    logic [63:0] s;
    s = d >> (8 * off);
    case (sz)
      0: exp_load = sg ? {{56{s[7]}}, s[7:0]} : {56'd0, s[7:0]};
      1: exp_load = sg ? {{48{s[15]}}, s[15:0]} : {48'd0, s[15:0]};
      2: exp_load = sg ? {{32{s[31]}}, s[31:0]} : {32'd0, s[31:0]};
      default: exp_load = s;
    endcase
  endfunction

  // scoreboard monitor: compares each transferred load result
  always @(negedge clk) begin
    #3;
    if (!rst && out_valid && out_ready) begin
      if (sb_q.size() == 0) chk(1'b0, "R9/R10 unexpected result", out_data, 64'h0);
      else begin
        logic [63:0] e;
        e = sb_q.pop_front();
        chk(out_data == e, "R9/R10 load result", out_data, e);
      end
    end
  end

  task automatic do_req(input logic [63:0] addr, input int sz, input bit st, input bit sg,
                        input logic [63:0] wd, input logic [63:0] rdata, input int stall);
    bit   bad;
    int   off;
    logic [63:0] e_wd;
    logic [15:0] e_strb;
    int   left;
    bad    = (addr % (64'd1 << sz)) != 0;
    off    = int'(addr[2:0]);
    e_wd   = wd << (8 * off);
    e_strb = st ? (((16'd1 << (1 << sz)) - 16'd1) << off) : 16'd0;
    left   = stall;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_size = 2'(sz);
    req_store = st; req_signed = sg; req_wdata = wd;
    mem_ready = (left == 0);
    while (left > 0) begin
      #2;
      chk(!req_ready && mem_valid, "R6 stall under back-pressure", {62'd0, req_ready, mem_valid}, 64'd1);
      @(negedge clk);
      left--;
      mem_ready = (left == 0);
    end
    #2;
    if (bad) begin
      chk(req_ready && !mem_valid, "R5 fault consumed, not issued", {62'd0, req_ready, mem_valid}, 64'd2);
    end else begin
      chk(mem_valid && req_ready && mem_addr == addr, "R6 forward address", mem_addr, addr);
      chk(mem_store == st && !mem_fetch, "R6 store/fetch flags", {62'd0, mem_store, mem_fetch}, {62'd0, st, 1'b0});
      chk(mem_wstrb == e_strb[7:0], st ? "R7 store strobe" : "R8 load strobe", {56'd0, mem_wstrb}, {56'd0, e_strb[7:0]});
      if (st) chk(mem_wdata == e_wd, "R7 store lane data", mem_wdata, e_wd);
    end
    @(negedge clk);
    req_valid = 1'b0; mem_ready = 1'b0;
    #2;
    if (bad) begin
      exp_fault = addr;
      chk(trap_valid && trap_cause == (st ? 2'b10 : 2'b01), st ? "R3 store trap code" : "R2 load trap code",
          {62'd0, trap_cause}, {62'd0, st ? 2'b10 : 2'b01});
    end else begin
      chk(!trap_valid && trap_cause == 2'b00, "R2 no trap on aligned", {62'd0, trap_cause}, 64'd0);
    end
    chk(fault_addr == exp_fault, "R4 fault address", fault_addr, exp_fault);
    if (bad) begin
      @(negedge clk); #2;
      chk(!trap_valid, "R2 trap is one cycle", {63'd0, trap_valid}, 64'd0);
    end
    if (!bad && !st) begin
      sb_q.push_back(exp_load(rdata, off, sz, sg));
      // a new aligned store must wait while the load is pending
      req_valid = 1'b1; req_store = 1'b1; req_addr = 64'h100; req_size = 2'd3; mem_ready = 1'b1;
      #1;
      chk(!req_ready && !mem_valid, "R11 pending blocks requests", {62'd0, req_ready, mem_valid}, 64'd0);
      @(negedge clk);
      req_valid = 1'b0; mem_ready = 1'b0;
      rsp_valid = 1'b1; rsp_data = rdata; out_ready = 1'b0;
      #2;
      chk(out_valid && !rsp_ready, "R11 result held off", {62'd0, out_valid, rsp_ready}, 64'd2);
      @(negedge clk);
      out_ready = 1'b1;
      #2;
      chk(rsp_ready, "R11 rsp_ready follows out_ready", {63'd0, rsp_ready}, 64'd1);
      @(negedge clk);
      rsp_valid = 1'b0; out_ready = 1'b0;
      #2;
      chk(!out_valid && fault_addr == exp_fault, "R11 pending cleared / R4 hold", fault_addr, exp_fault);
    end
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    chk(!trap_valid && trap_cause == 2'b00 && fault_addr == '0 && !out_valid,
        "R12 reset state", fault_addr, 64'd0);
    chk(req_ready == 1'b0 && mem_valid == 1'b0, "R12 idle after reset", {62'd0, req_ready, mem_valid}, 64'd0);

    // R9/R10 loads across sizes and lanes
    do_req(64'h1000_0005, 0, 0, 0, 0, 64'h0123_8A67_89AB_CDEF, 0); // R9 byte lane 5 zero
    do_req(64'h1000_0005, 0, 0, 1, 0, 64'h0123_8A67_89AB_CDEF, 0); // R10 byte sign fill
    do_req(64'h1000_0006, 1, 0, 1, 0, 64'hF00D_1234_5678_9ABC, 0); // R10 half
    do_req(64'h1000_0006, 1, 0, 0, 0, 64'hF00D_1234_5678_9ABC, 0); // R9 half
    do_req(64'h2000_0004, 2, 0, 0, 0, 64'h8765_4321_0FED_CBA9, 0); // R9 word zero ext
    do_req(64'h2000_0000, 2, 0, 1, 0, 64'h1111_2222_9ABC_DEF0, 1); // R10 word, stalled R6
    do_req(64'h3000_0008, 3, 0, 1, 0, 64'hFEDC_BA98_7654_3210, 0); // R9 dword
    do_req(64'h3000_0003, 0, 0, 1, 0, 64'h0000_0000_7F00_0000, 0); // R1 odd byte ok, positive

    // R1/R2/R4/R5 misaligned loads
    do_req(64'h4000_0001, 1, 0, 0, 0, 0, 0);
    do_req(64'h4000_0004, 3, 0, 1, 0, 0, 0);  // R1 8-byte at 4-byte boundary
    // R3 misaligned store
    do_req(64'h5000_0006, 2, 1, 0, 64'hDEAD_BEEF, 0, 0);

    // R7 aligned stores, fault_addr must hold (R4)
    do_req(64'h6000_0003, 0, 1, 0, 64'h0000_0000_0000_00A5, 0, 0);
    do_req(64'h6000_0002, 1, 1, 0, 64'h0000_0000_0000_BEEF, 0, 2);
    do_req(64'h6000_0004, 2, 1, 0, 64'h0000_0000_CAFE_F00D, 0, 0);
    do_req(64'h6000_0008, 3, 1, 0, 64'h0102_0304_0506_0708, 0, 0);
    do_req(64'h7000_0002, 2, 0, 0, 0, 0, 0);  // R2 another load fault overwrites R4

    repeat (2) @(negedge clk);
    chk(sb_q.size() == 0, "R9/R10 all results seen", 64'(sb_q.size()), 64'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule